// File: doc/BRIEF.md
# Sliding-Window Product-Term Allocator

This block steers a bank of product terms into the OR gates of a row of macrocells. The terms arrive as groups of four, one group (a cluster) per macrocell position. Each cluster carries a two-bit steering code. The code either leaves the cluster idle or hands it to one of three macrocells: the one to its left, the one at its own position, or the one to its right. Each macrocell output is the OR of every term in every cluster steered to it. A macrocell can therefore collect at most three clusters, which is twelve terms with the default sizes.

The steering pattern is static configuration. A code at either end of the row that points past the last macrocell is illegal. Such a code raises the configuration-error output, and its cluster is dropped from every sum. The sums and the error flag are registered once. They update one clock after the inputs, and a synchronous active-low reset clears them. The reset drives the single register stage, which moves from its cleared state to tracking the inputs when the reset is released.

Top module: `palloc_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `sum_o` and `cfg_err_o` are 0 after that edge.
- R2: The outputs are registered. `sum_o` and `cfg_err_o` reflect the `pterm_i` and `steer_i` values present at the previous rising edge, and they do not change between edges.
- R3: Cluster c consists of `pterm_i[4c+3:4c]`, and its code is `steer_i[2c+1:2c]`. Code 2 (own) ORs all four terms of cluster c into `sum_o[c]`.
- R4: Code 1 (left) on cluster c, for c from 1 to 15, ORs its four terms into `sum_o[c-1]`.
- R5: Code 3 (right) on cluster c, for c from 0 to 14, ORs its four terms into `sum_o[c+1]`.
- R6: Code 0 (none) makes the cluster contribute to no sum, whatever the values of its terms.
- R7: A macrocell that no cluster is steered to has a sum of 0, even when every term is 1.
- R8: Code 1 on cluster 0, or code 3 on cluster 15, sets `cfg_err_o` to 1, and that cluster contributes to no sum.
- R9: A macrocell k can draw from clusters k-1 (code 3), k (code 2) and k+1 (code 1) at the same time. Its sum is 1 when any one of those twelve terms is 1.
- R10: `cfg_err_o` returns to 0 one edge after the configuration becomes legal again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pterm_i | input | 64 | Product-term values, four per cluster, cluster 0 in the low bits |
| steer_i | input | 32 | Two-bit steering code per cluster, cluster 0 in the low bits |
| sum_o | output | 16 | Registered sum-of-products, one bit per macrocell |
| cfg_err_o | output | 1 | Registered flag for a code that steers off either end of the row |

## Verification
The bench goes after the row ends, where a code pointing off the edge must raise the error and must not wrap onto the opposite macrocell. A design that swapped the left and right directions, or that leaked a dropped cluster into a neighbour, shows a wrong sum there. One macrocell is fed from all three of its window clusters, one term at a time. This exposes a gather that drops one source or that ORs in only part of a cluster. Every term is then driven to 1 while only that macrocell is claimed. This catches a macrocell that picks up an unassigned cluster. Between edges the inputs change while the outputs are watched. This catches a design that responds before the clock.

// File: rtl/palloc_pkg.sv
package palloc_pkg;

    typedef enum logic [1:0] {
        STEER_NONE  = 2'd0,
        STEER_LEFT  = 2'd1,
        STEER_OWN   = 2'd2,
        STEER_RIGHT = 2'd3
    } steer_e;

endpackage

// File: rtl/palloc_cluster_or.sv
module palloc_cluster_or #(
    parameter int TPC = 4
) (
    input  logic [TPC-1:0] terms_i,
    output logic           hit_o
);
    // Any asserted term in the group makes the cluster contribute a 1.
    assign hit_o = |terms_i;
endmodule

// File: rtl/palloc_steer_decode.sv
module palloc_steer_decode
    import palloc_pkg::*;
(
    input  steer_e code_i,
    output logic   to_left_o,
    output logic   to_own_o,
    output logic   to_right_o
);
    always_comb begin
        to_left_o  = 1'b0;
        to_own_o   = 1'b0;
        to_right_o = 1'b0;
        unique case (code_i)
            STEER_NONE:  ;
            STEER_LEFT:  to_left_o  = 1'b1;
            STEER_OWN:   to_own_o   = 1'b1;
            STEER_RIGHT: to_right_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/palloc_mc_gather.sv
module palloc_mc_gather (
    input  logic lo_hit_i,
    input  logic lo_sel_i,
    input  logic own_hit_i,
    input  logic own_sel_i,
    input  logic hi_hit_i,
    input  logic hi_sel_i,
    output logic sum_o
);
    // Three-source window: lower neighbour, own cluster, upper neighbour.
    assign sum_o = (lo_hit_i  & lo_sel_i)
                 | (own_hit_i & own_sel_i)
                 | (hi_hit_i  & hi_sel_i);
endmodule

// File: rtl/palloc_top.sv
module palloc_top
    import palloc_pkg::*;
#(
    parameter int N_MC = 16,
    parameter int TPC  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_MC*TPC-1:0] pterm_i,
    input  logic [2*N_MC-1:0]   steer_i,
    output logic [N_MC-1:0]     sum_o,
    output logic                cfg_err_o
);
    localparam int LAST = N_MC - 1;

    logic [N_MC-1:0] hit;
    logic [N_MC-1:0] to_l;
    logic [N_MC-1:0] to_o;
    logic [N_MC-1:0] to_r;
    logic [N_MC-1:0] sum_d;
    logic            err_d;

    // Per-cluster term OR and steering decode.
    for (genvar c = 0; c < N_MC; c++) begin : g_cluster
        palloc_cluster_or #(.TPC(TPC)) u_or (
            .terms_i (pterm_i[c*TPC +: TPC]),
            .hit_o   (hit[c])
        );
        palloc_steer_decode u_dec (
            .code_i     (steer_e'(steer_i[2*c +: 2])),
            .to_left_o  (to_l[c]),
            .to_own_o   (to_o[c]),
            .to_right_o (to_r[c])
        );
    end

    // Per-macrocell window gather; the row ends see no outer neighbour.
    for (genvar k = 0; k < N_MC; k++) begin : g_mc
        if (k == 0) begin : g_first
            palloc_mc_gather u_g (
                .lo_hit_i  (1'b0),       .lo_sel_i  (1'b0),
                .own_hit_i (hit[k]),     .own_sel_i (to_o[k]),
                .hi_hit_i  (hit[k+1]),   .hi_sel_i  (to_l[k+1]),
                .sum_o     (sum_d[k])
            );
        end else if (k == LAST) begin : g_last
            palloc_mc_gather u_g (
                .lo_hit_i  (hit[k-1]),   .lo_sel_i  (to_r[k-1]),
                .own_hit_i (hit[k]),     .own_sel_i (to_o[k]),
                .hi_hit_i  (1'b0),       .hi_sel_i  (1'b0),
                .sum_o     (sum_d[k])
            );
        end else begin : g_mid
            palloc_mc_gather u_g (
                .lo_hit_i  (hit[k-1]),   .lo_sel_i  (to_r[k-1]),
                .own_hit_i (hit[k]),     .own_sel_i (to_o[k]),
                .hi_hit_i  (hit[k+1]),   .hi_sel_i  (to_l[k+1]),
                .sum_o     (sum_d[k])
            );
        end
    end

    // Spill off either end of the row is the only illegal steering.
    assign err_d = to_l[0] | to_r[LAST];

    // Output register stage (synchronous reset).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_o     <= '0;
            cfg_err_o <= 1'b0;
        end else begin
            sum_o     <= sum_d;
            cfg_err_o <= err_d;
        end
    end
endmodule

// File: rtl/palloc_chk.sv
module palloc_chk #(
    parameter int N_MC = 16,
    parameter int TPC  = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_MC*TPC-1:0] pterm_i,
    input logic [2*N_MC-1:0]   steer_i,
    input logic [N_MC-1:0]     sum_o,
    input logic                cfg_err_o
);
    localparam int LAST = N_MC - 1;

    // R1: reset clears both outputs on the next edge.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (sum_o == '0 && !cfg_err_o));

    // R2: with inputs held across an edge, registered outputs hold too.
    assert_hold_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(pterm_i) && $stable(steer_i)) |=> $stable(sum_o));

    // R6: no active term means no active sum.
    assert_zero_terms_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pterm_i == '0) |=> (sum_o == '0));

    // R8: end-of-row spill raises the error.
    assert_edge_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (steer_i[1:0] == 2'd1 || steer_i[2*LAST +: 2] == 2'd3) |=> cfg_err_o);

    // R10: a legal configuration clears the error.
    assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (steer_i[1:0] != 2'd1 && steer_i[2*LAST +: 2] != 2'd3) |=> !cfg_err_o);

    // R7: a macrocell nobody targets stays 0.
    for (genvar k = 0; k < N_MC; k++) begin : g_unclaimed
        logic from_lo, from_hi;
        if (k == 0) begin : g_lo0
            assign from_lo = 1'b0;
        end else begin : g_lo
            assign from_lo = (steer_i[2*(k-1) +: 2] == 2'd3);
        end
        if (k == LAST) begin : g_hi0
            assign from_hi = 1'b0;
        end else begin : g_hi
            assign from_hi = (steer_i[2*(k+1) +: 2] == 2'd1);
        end
        assert_unclaimed_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!from_lo && !from_hi && steer_i[2*k +: 2] != 2'd2) |=> !sum_o[k]);
    end
endmodule

bind palloc_top palloc_chk #(.N_MC(N_MC), .TPC(TPC)) u_palloc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pterm_i   (pterm_i),
    .steer_i   (steer_i),
    .sum_o     (sum_o),
    .cfg_err_o (cfg_err_o)
);

// File: tb/tb_palloc_top.sv
module tb_palloc_top;
    localparam int N_MC = 16;
    localparam int TPC  = 4;
    localparam int NV   = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [N_MC*TPC-1:0] pterm_i = '0;
    logic [2*N_MC-1:0]   steer_i = '0;
    logic [N_MC-1:0]     sum_o;
    logic                cfg_err_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    palloc_top #(.N_MC(N_MC), .TPC(TPC)) dut (
        .clk(clk), .rst_n(rst_n), .pterm_i(pterm_i), .steer_i(steer_i),
        .sum_o(sum_o), .cfg_err_o(cfg_err_o)
    );

    always #5 clk = ~clk;

    // Stimulus table: {steer (32), pterm (64)}
    localparam logic [95:0] VEC [NV] = '{
        {32'hAAAA_AAAA, 64'h0001_0020_0300_4000},  // all own
        {32'h0000_0000, 64'hFFFF_FFFF_FFFF_FFFF},  // all none
        {32'h5555_5554, 64'h8000_0100_0020_0004},  // all left
        {32'h3FFF_FFFF, 64'h1000_0200_0030_0008},  // all right
        {32'h0000_0001, 64'hFFFF_FFFF_FFFF_FFFF},  // cluster 0 off left end
        {32'hC000_0000, 64'hFFFF_FFFF_FFFF_FFFF},  // cluster 15 off right end
        {32'h9E1B_27C6, 64'h0F0F_00F0_F000_0F0F},  // mixed
        {32'h6A6A_6A6A, 64'h0000_FFFF_0000_1111}   // mixed 2
    };

    function automatic string tag_of(int i);
        case (i)
            0: return "R3";
            1: return "R6";
            2: return "R4";
            3: return "R5";
            4, 5: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Reference from the requirements: {err, sums}
    function automatic logic [N_MC:0] model(logic [N_MC*TPC-1:0] pt, logic [2*N_MC-1:0] cfg);
        logic [N_MC-1:0] s;
        logic e;
        logic h;
        s = '0;
        e = 1'b0;
        for (int c = 0; c < N_MC; c++) begin
            h = |pt[c*TPC +: TPC];
            case (cfg[2*c +: 2])
                2'd1: if (c == 0) e = 1'b1; else s[c-1] = s[c-1] | h;
                2'd2: s[c] = s[c] | h;
                2'd3: if (c == N_MC-1) e = 1'b1; else s[c+1] = s[c+1] | h;
                default: ;
            endcase
        end
        return {e, s};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(logic [2*N_MC-1:0] cfg, logic [N_MC*TPC-1:0] pt);
        @(negedge clk);
        steer_i = cfg;
        pterm_i = pt;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [N_MC:0] exp;
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 sum", 32'(sum_o), 32'h0);
        check("R1 err", 32'(cfg_err_o), 32'h0);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][95:64], VEC[i][63:0]);
            exp = model(VEC[i][63:0], VEC[i][95:64]);
            check({tag_of(i), " sum"}, 32'(sum_o), 32'(exp[N_MC-1:0]));
            check({tag_of(i), " err"}, 32'(cfg_err_o), 32'(exp[N_MC]));
        end

        // R10: error clears after legal config (previous vector was legal; redo)
        apply(32'h0000_0001, 64'h0);
        check("R8 err set", 32'(cfg_err_o), 32'h1);
        apply(32'h0000_0002, 64'h0);
        check("R10 err clear", 32'(cfg_err_o), 32'h0);

        // R8: dropped cluster 0 must not wrap to macrocell 15
        apply(32'h0000_0001, 64'h0000_0000_0000_000F);
        check("R8 dropped", 32'(sum_o), 32'h0);

        // R9: macrocell 5 fed by cluster 4 right, 5 own, 6 left, one term at a time
        apply(32'h0000_1B00, 64'h0000_0000_0100_0000);
        check("R9 from hi neighbour", 32'(sum_o), 32'h0020);
        apply(32'h0000_1B00, 64'h0000_0000_0080_0000);
        check("R9 own top term", 32'(sum_o), 32'h0020);
        apply(32'h0000_1B00, 64'h0000_0000_0001_0000);
        check("R9 from lo neighbour", 32'(sum_o), 32'h0020);
        // R7: all terms high, only macrocell 5 claimed
        apply(32'h0000_1B00, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R7 only claimed", 32'(sum_o), 32'h0020);

        // R2: change inputs between edges; output holds until the edge
        @(negedge clk);
        steer_i = 32'hAAAA_AAAA;
        pterm_i = 64'h0000_0000_0000_0001;
        #2;
        check("R2 hold", 32'(sum_o), 32'h0020);
        @(posedge clk);
        @(negedge clk);
        check("R2 update", 32'(sum_o), 32'h0001);

        // R1: reset mid-run with active inputs
        steer_i = 32'h0000_0001;
        rst_n   = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid sum", 32'(sum_o), 32'h0);
        check("R1 mid err", 32'(cfg_err_o), 32'h0);
        rst_n = 1'b1;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule